// File: doc/BRIEF.md
# ECC Error Flag and Address Logger

This block collects error reports from a group of ECC-protected memories. Each memory reports a corrected (single-bit) or uncorrectable (double-bit) event as a one-cycle pulse on its own bit of two event vectors. Alongside the pulses come the failing address, the bank and whether the failing access was a data or a tag lookup. The block keeps two sticky flag registers. One records every error. The other records only the errors that were not double-bit errors. Software clears the flags by writing 1 to them.

A per-memory enable register masks the all-errors flags into a single interrupt line. A capture word records where the first error happened. It holds a data half and a tag half, and each half has its own address, bank and valid bit. The capture word locks on the first error and reloads only after software has cleared every all-errors flag.

Register access uses a 2-bit select, shared by writes and combinational reads. Select 0 is the all-errors flags, 1 is the non-double flags, 2 is the interrupt enable and 3 is the capture word.

Top module: `ecc_err_logger`

## Requirements
- R1: While reset is asserted and right after it is released, all four registers read 0 and `irq` is 0.
- R2: A single or double event on an implemented bit sets that bit of the all-errors register (select 0) at the next clock edge. The bit then stays set until software clears it.
- R3: Only bit positions 0 to 6, 8 and 10 are implemented. Events, writes and enables at any other position are ignored, and those positions always read 0 in selects 0, 1 and 2.
- R4: A write to select 0 or select 1 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: The non-double register (select 1) sets a bit only for a single event with no double event on the same bit in the same cycle.
- R6: If a hardware set and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R7: The interrupt enable register (select 2) is loaded by a write to select 2. It keeps only the implemented positions.
- R8: `irq` is high exactly when some bit is set in both the all-errors register and the enable register. `irq` follows the register values with no further delay.
- R9: A captured data access reads as address in bits 13:0, bank in bit 14 and 1 in bit 15, with bits 31:16 at 0. A captured tag access reads as address in bits 29:16, bank in bit 30 and 1 in bit 31, with bits 15:0 at 0.
- R10: Capture happens on an implemented event only when the all-errors register was all zero just before that edge. Otherwise the capture word holds its value. Once every all-errors flag has been cleared, the next error captures again.
- R11: The capture word is read-only. A write to select 3 has no effect on it.
- R12: `rd_data` shows the register chosen by `rd_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_single | input | 32 | Single-bit error pulses, one bit per memory |
| ev_double | input | 32 | Double-bit error pulses, one bit per memory |
| ev_is_tag | input | 1 | 1 when the failing access was a tag lookup |
| ev_addr | input | 14 | Failing address |
| ev_bank | input | 1 | Failing bank |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives single and double events across all 32 bit positions, so a design that decoded the implemented mask wrongly would show flags at reserved positions or miss real ones. Further tests cover a write-1 clear landing in the same cycle as a new event, and a single and a double event on the same bit together. A design that gave priority to the clear, or that recorded a double event as non-double, would read back the wrong flag. The capture word is checked across a second error, a partial clear and a full clear: a design without the lock would overwrite the first location, and one that never unlocked would keep stale data. A long pseudo-random stretch then mixes events, clears and enable writes against a model built from the requirements.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  // Register select encoding, shared by write and read ports
  typedef enum logic [1:0] {
    SEL_ALL = 2'd0,
    SEL_ND  = 2'd1,
    SEL_IE  = 2'd2,
    SEL_CAP = 2'd3
  } ecc_sel_e;

  // Positions 0..6 (RAM blocks), 8 and 10 (caches) are implemented
  localparam logic [31:0] DEF_FLAG_MASK = 32'h0000_057F;
  localparam int          DEF_ADDR_W    = 14;
endpackage

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank #(
  parameter int           W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flags_q
);
  logic [W-1:0] clr_v;
  logic [W-1:0] flags_d;
  logic         upd;

  // Set has priority over a write-1 clear on the same bit
  always_comb begin
    clr_v   = clr_en ? clr_bits : '0;
    flags_d = ((flags_q & ~clr_v) | set_i) & MASK;
    upd     = clr_en | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end
endmodule

// File: rtl/ecc_addr_capture.sv
module ecc_addr_capture #(
  parameter int ADDR_W = 14,
  localparam int HALF_W = ADDR_W + 2,
  localparam int CAP_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              is_tag,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank,
  output logic [CAP_W-1:0]  cap_q
);
  logic [HALF_W-1:0] half;
  logic [CAP_W-1:0]  cap_d;

  always_comb begin
    half  = {1'b1, bank, addr};
    cap_d = is_tag ? {half, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, half};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end
endmodule

// File: rtl/ecc_irq_merge.sv
module ecc_irq_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0] flags,
  input  logic [W-1:0] enables,
  output logic         irq
);
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_hit
    assign hit[i] = flags[i] & enables[i];
  end

  assign irq = |hit;
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  localparam int REG_W = 2 * (ADDR_W + 2),
  parameter logic [REG_W-1:0] FLAG_MASK = REG_W'(DEF_FLAG_MASK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  ev_single,
  input  logic [REG_W-1:0]  ev_double,
  input  logic              ev_is_tag,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_bank,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  logic [REG_W-1:0] any_set, nd_set;
  logic [REG_W-1:0] any_q, nd_q, ie_q, ie_d, cap_q;
  logic             clr_any, clr_nd, ie_we, cap_en;

  always_comb begin
    any_set = (ev_single | ev_double) & FLAG_MASK;
    nd_set  = ev_single & ~ev_double & FLAG_MASK;
    clr_any = wr_en && (wr_sel == SEL_ALL);
    clr_nd  = wr_en && (wr_sel == SEL_ND);
    ie_we   = wr_en && (wr_sel == SEL_IE);
    ie_d    = wr_data & FLAG_MASK;
    // capture locked while any all-errors flag is still set
    cap_en  = (|any_set) && (any_q == '0);
  end

  ecc_flag_bank #(.W(REG_W), .MASK(FLAG_MASK)) u_any (
    .clk(clk), .rst_n(rst_n), .set_i(any_set),
    .clr_en(clr_any), .clr_bits(wr_data), .flags_q(any_q)
  );

  ecc_flag_bank #(.W(REG_W), .MASK(FLAG_MASK)) u_nd (
    .clk(clk), .rst_n(rst_n), .set_i(nd_set),
    .clr_en(clr_nd), .clr_bits(wr_data), .flags_q(nd_q)
  );

  ecc_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .is_tag(ev_is_tag),
    .addr(ev_addr), .bank(ev_bank), .cap_q(cap_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= '0;
    else if (ie_we) ie_q <= ie_d;
  end

  ecc_irq_merge #(.W(REG_W)) u_irq (
    .flags(any_q), .enables(ie_q), .irq(irq)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_ALL: rd_data = any_q;
      SEL_ND:  rd_data = nd_q;
      SEL_IE:  rd_data = ie_q;
      default: rd_data = cap_q;
    endcase
  end
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk #(
  parameter int REG_W = 32,
  parameter logic [REG_W-1:0] FLAG_MASK = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] ev_single,
  input logic [REG_W-1:0] ev_double,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic             irq,
  input logic [REG_W-1:0] flags_any,
  input logic [REG_W-1:0] flags_nd,
  input logic [REG_W-1:0] ie,
  input logic [REG_W-1:0] cap
);
  logic [REG_W-1:0] keep_bits, ev_bits;

  always_comb begin
    keep_bits = flags_any & ~((wr_en && wr_sel == 2'd0) ? wr_data : '0);
    ev_bits   = (ev_single | ev_double) & FLAG_MASK;
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_any & $past(keep_bits)) == $past(keep_bits)));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bits != '0) |=> ((flags_any & $past(ev_bits)) == $past(ev_bits)));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_any | flags_nd | ie) & ~FLAG_MASK) == '0);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_any != '0));

  assert_capture_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_any != '0) |=> $stable(cap));

  assert_one_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap[REG_W-1], cap[REG_W/2-1]}));
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.REG_W(REG_W), .FLAG_MASK(FLAG_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_single(ev_single), .ev_double(ev_double),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq),
  .flags_any(any_q), .flags_nd(nd_q), .ie(ie_q), .cap(cap_q)
);

// File: tb/test_ecc_err_logger.sv
module test_ecc_err_logger;
  localparam logic [31:0] M = 32'h0000_057F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ev_single, ev_double, wr_data, rd_data;
  logic        ev_is_tag, ev_bank, wr_en, irq;
  logic [13:0] ev_addr;
  logic [1:0]  wr_sel, rd_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] m_any, m_nd, m_ie, m_cap;

  always #10 clk = ~clk;

  ecc_err_logger i_ecc_err_logger (
    .clk(clk), .rst_n(rst_n), .ev_single(ev_single), .ev_double(ev_double),
    .ev_is_tag(ev_is_tag), .ev_addr(ev_addr), .ev_bank(ev_bank),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    rd_sel = 2'd0; #1 cmp(req, "all-errors", rd_data, m_any);
    rd_sel = 2'd1; #1 cmp(req, "non-double", rd_data, m_nd);
    rd_sel = 2'd2; #1 cmp(req, "enable", rd_data, m_ie);
    rd_sel = 2'd3; #1 cmp(req, "capture", rd_data, m_cap);
    cmp(req, "irq (R8)", {31'b0, irq}, {31'b0, |(m_any & m_ie)});
  endtask

  task automatic idle_inputs();
    ev_single = '0; ev_double = '0; ev_is_tag = 1'b0; ev_addr = '0; ev_bank = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
  endtask

  // Advance one clock, updating the model from the requirements
  task automatic tick();
    logic [31:0] ev, nds, c0, c1, n_any, n_nd, n_ie, n_cap;
    logic [15:0] hv;
    ev  = (ev_single | ev_double) & M;
    nds = ev_single & ~ev_double & M;
    c0  = (wr_en && wr_sel == 2'd0) ? wr_data : '0;
    c1  = (wr_en && wr_sel == 2'd1) ? wr_data : '0;
    n_any = ((m_any & ~c0) | ev) & M;
    n_nd  = ((m_nd & ~c1) | nds) & M;
    n_ie  = (wr_en && wr_sel == 2'd2) ? (wr_data & M) : m_ie;
    n_cap = m_cap;
    if (ev != 0 && m_any == 0) begin
      hv    = {1'b1, ev_bank, ev_addr};
      n_cap = ev_is_tag ? {hv, 16'h0} : {16'h0, hv};
    end
    @(posedge clk); #2;
    m_any = n_any; m_nd = n_nd; m_ie = n_ie; m_cap = n_cap;
    idle_inputs();
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
  endtask

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; rd_sel = '0;
    idle_inputs();
    m_any = 0; m_nd = 0; m_ie = 0; m_cap = 0;
    repeat (3) @(posedge clk);
    #2 check_all("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2 check_all("R1");

    // Single events on every position: R2 R3 R5 R9 R10, then clear R4
    for (int b = 0; b < 32; b++) begin
      ev_single = 32'h1 << b; ev_addr = 14'((b * 613) ^ 14'h2A5A);
      ev_bank = b[0]; ev_is_tag = b[1];
      tick(); check_all("R2 R3 R5 R9");
      wr(2'd0, 32'h1 << b); tick(); check_all("R4");
      wr(2'd1, 32'h1 << b); tick(); check_all("R4");
    end
    // Double events on every position: nd must stay clear (R5)
    for (int b = 0; b < 32; b++) begin
      ev_double = 32'h1 << b; ev_addr = 14'(b * 211); ev_bank = b[2]; ev_is_tag = b[0];
      if (b % 3 == 0) ev_single = 32'h1 << b;
      tick(); check_all("R5 R9");
      wr(2'd0, '1); tick(); check_all("R4");
    end
    // Enable register writes, reserved bits dropped (R7 R3)
    wr(2'd2, 32'hFFFF_FFFF); tick(); check_all("R7");
    wr(2'd2, 32'hA5A5_0002); tick(); check_all("R7");
    // irq gating (R8)
    ev_single = 32'h0000_0001; ev_addr = 14'h1234; tick(); check_all("R8 masked");
    wr(2'd2, 32'h0000_0001); tick(); check_all("R8 enabled");
    // Capture lock: second error does not overwrite (R10)
    ev_double = 32'h0000_0400; ev_addr = 14'h3FFF; ev_is_tag = 1'b1; ev_bank = 1'b1;
    tick(); check_all("R10 locked");
    wr(2'd0, 32'h0000_0001); tick(); check_all("R10 partial clear");
    ev_single = 32'h0000_0004; ev_addr = 14'h0111; tick(); check_all("R10 still locked");
    // Set wins over clear in the same cycle (R6)
    wr(2'd0, 32'h0000_0404); ev_single = 32'h0000_0004; tick(); check_all("R6");
    wr(2'd1, 32'h0000_0004); ev_single = 32'h0000_0004; tick(); check_all("R6 nd");
    wr(2'd0, '1); tick(); check_all("R10 full clear");
    ev_single = 32'h0000_0100; ev_addr = 14'h2222; ev_is_tag = 1'b1; tick(); check_all("R10 recapture R9");
    // Capture is read-only (R11)
    wr(2'd3, 32'h0F0F_F0F0); tick(); check_all("R11");
    // Pseudo-random mix (R12 over all selects)
    lf = 32'hACE1_2345;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[3:2] == 2'b00) ev_single = 32'h1 << lf[8:4];
      if (lf[12:10] == 3'b000) ev_double = 32'h1 << lf[17:13];
      if (lf[19:18] == 2'b01) ev_double = ev_single;
      ev_addr = lf[31:18]; ev_bank = lf[9]; ev_is_tag = lf[1];
      if (lf[22:20] == 3'b101) wr(lf[24:23], lf ^ 32'h5555_0505);
      tick(); check_all("R12 random");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule